// File: doc/BRIEF.md
# Three-Bank Level Interrupt Controller

This block collects 96 level-sensitive interrupt lines, grouped as three banks of 32, and folds them into two processor requests: a normal request (IRQ) and a fast request (FIQ). Each line carries a 6-bit priority and a routing bit that selects the request class it feeds. Software sees a 4 KB window of 32-bit words. Through it, software masks and unmasks lines, including atomic set and clear aliases. It can also raise software interrupts, inspect the pending views per class, and read the winning line number of each class.

Each request output works on an arm-and-fire scheme. While an output is armed and the global mask is clear, the first cycle that shows an unmasked pending line of its class sets the output and freezes the winning line number. The output then stays high until software re-arms it through the control word. Reading a winner code has no side effects. A soft reset through the system configuration word returns every register to its power-up value.

Top module: `banked_irq_ctrl`

## Requirements
- R1: Offset 0x00 reads 0x21 and offset 0x14 reads 1. In the system word at 0x10, bit 0 is read/write. The idle word at 0x50 holds read/write bits [1:0], and all its other bits read 0. Bit 2 of the control word at 0x48 reads back the global mask.
- R2: After reset every mask bit is 1. All other state is 0, both outputs are low and both codes read 0. Writing 1 to bit 1 of 0x10 restores this state at that write's clock edge.
- R3: Bank b (0..2) occupies 0x80+0x20*b. Offset +0x00 reads the line inputs as registered at the last clock edge. Offset +0x04 is the mask, read/write. A write to +0x08 clears the mask bits where the data is 1, and a write to +0x0C sets them. Both alias words read 0.
- R4: A write to bank offset +0x10 sets software-interrupt bits, and reading that word returns the software bits. A write to +0x14 clears them, and that word reads 0. A line is pending while its registered input or its software bit is 1.
- R5: Bank offset +0x18 reads pending AND NOT mask AND NOT route. Offset +0x1C reads pending AND NOT mask AND route.
- R6: The word at 0x100+4*n (n = 0..95) configures line n. Bits [7:2] hold the priority and bit 0 routes the line to FIQ when 1. The word reads back those fields with all other bits 0.
- R7: Among the unmasked pending lines of one class, the lowest priority value wins, and a tie goes to the higher line number. The winner's global line number reads at 0x40 (IRQ) and 0x44 (FIQ), and reading it changes nothing.
- R8: An armed output fires when the global mask is clear and its class has a candidate. It rises on the clock edge after the one that registered the candidate. It then stays high with its code frozen until it is re-armed.
- R9: Writing 1 to bit 0 (IRQ) or bit 1 (FIQ) of 0x48 drops that output at the write edge and arms it. The output fires again one edge later if a candidate exists.
- R10: While control bit 2 (global mask) is 1, both outputs are low and neither fires.
- R11: A write is ignored, and a read returns 0, in these cases: bank index 3 (0xE0-0xFF), configuration beyond line 95, unmapped or unaligned addresses. Writes to read-only words are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Write strobe, one cycle per write |
| busRd | input | 1 | Read enable; read data is combinational |
| busAddr | input | 12 | Byte address inside the window |
| busWData | input | 32 | Write data |
| busRData | output | 32 | Read data, 0 when not reading |
| lineIn | input | 96 | Level interrupt inputs, line n on bit n |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |

## Verification
A wrong mask, route or priority bit first shows up as the wrong request class firing, or as a wrong winner code. The code freezes at the fire edge, so one corrupt cycle stays visible in the 0x40/0x44 reads until the next re-arm. The bench re-arms and reads the codes after every configuration change. A stuck arm flag shows one cycle after a candidate appears, as a request output that disagrees with a per-cycle behavioural model compared on every clock.

// File: rtl/bic_pkg.sv
package bic_pkg;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 12;
  localparam int NUM_BANKS  = 3;
  localparam int BANK_LINES = DATA_W;
  localparam int NUM_LINES  = NUM_BANKS * BANK_LINES;
  localparam int LINE_W     = $clog2(NUM_LINES);
  localparam int BANK_W     = 2;
  localparam int PRIO_W     = 6;

  typedef enum logic [3:0] {
    RS_NONE, RS_REV, RS_SYS, RS_STAT, RS_CODE_IRQ, RS_CODE_FIQ, RS_CTRL,
    RS_IDLE, RS_RAW, RS_MASK, RS_SWI, RS_PEND_IRQ, RS_PEND_FIQ, RS_CFG
  } rd_sel_e;

  typedef struct packed {
    logic                  maskWr;
    logic                  maskClr;
    logic                  maskSet;
    logic                  swiSet;
    logic                  swiClr;
    logic                  cfgWr;
    logic                  ctrlWr;
    logic                  sysWr;
    logic                  idleWr;
    logic                  softReset;
    logic                  irqRearm;
    logic                  fiqRearm;
    logic [BANK_W-1:0]     bank;
    logic [LINE_W-1:0]     line;
    rd_sel_e               rdSel;
  } strobe_t;
endpackage

// File: rtl/bic_arbiter.sv
module bic_arbiter #(
  parameter int N  = 96,
  parameter int PW = 6,
  parameter int IW = 7
) (
  input  logic [N-1:0]  cand,
  input  logic [PW-1:0] prio [N],
  output logic          valid,
  output logic [IW-1:0] winner
);
  logic [PW-1:0] best;

  // later lines win ties because of the <= comparison
  always_comb begin
    valid  = 1'b0;
    winner = '0;
    best   = '0;
    for (int l = 0; l < N; l++) begin
      if (cand[l] && (!valid || prio[l] <= best)) begin
        valid  = 1'b1;
        best   = prio[l];
        winner = IW'(l);
      end
    end
  end

  always_comb begin
    if (valid) begin
      assert_winner_pending_R7: assert (cand[winner]);
      for (int l = 0; l < N; l++) begin
        if (cand[l]) begin
          assert_no_better_R7: assert (prio[l] >= prio[winner]);
        end
      end
    end
  end
endmodule

// File: rtl/bic_ctrl.sv
module bic_ctrl
  import bic_pkg::*;
(
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [2:0]        wBits,
  output strobe_t           st
);
  localparam logic [ADDR_W-1:0] CFG_BASE = ADDR_W'('h100);
  localparam logic [ADDR_W-1:0] CFG_END  = CFG_BASE + ADDR_W'(4 * NUM_LINES);

  logic              aligned;
  logic              bankWin;
  logic              bankOk;
  logic              cfgWin;
  logic [ADDR_W-1:0] cfgOff;

  assign aligned = (busAddr[1:0] == 2'b00);
  assign bankWin = aligned && (busAddr[ADDR_W-1:7] == 5'h01);
  assign bankOk  = (int'(busAddr[6:5]) < NUM_BANKS);
  assign cfgWin  = aligned && (busAddr >= CFG_BASE) && (busAddr < CFG_END);
  assign cfgOff  = busAddr - CFG_BASE;

  always_comb begin
    st       = '0;
    st.rdSel = RS_NONE;
    st.bank  = busAddr[6:5];
    st.line  = cfgOff[LINE_W+1:2];
    if (bankWin) begin
      if (bankOk) begin
        unique case (busAddr[4:2])
          3'd0: st.rdSel = RS_RAW;
          3'd1: begin st.rdSel = RS_MASK; st.maskWr = busWr; end
          3'd2: st.maskClr = busWr;
          3'd3: st.maskSet = busWr;
          3'd4: begin st.rdSel = RS_SWI; st.swiSet = busWr; end
          3'd5: st.swiClr = busWr;
          3'd6: st.rdSel = RS_PEND_IRQ;
          3'd7: st.rdSel = RS_PEND_FIQ;
          default: ;
        endcase
      end
    end else if (cfgWin) begin
      st.rdSel = RS_CFG;
      st.cfgWr = busWr;
    end else if (aligned) begin
      unique case (busAddr)
        ADDR_W'('h000): st.rdSel = RS_REV;
        ADDR_W'('h010): begin
          st.rdSel     = RS_SYS;
          st.sysWr     = busWr;
          st.softReset = busWr && wBits[1];
        end
        ADDR_W'('h014): st.rdSel = RS_STAT;
        ADDR_W'('h040): st.rdSel = RS_CODE_IRQ;
        ADDR_W'('h044): st.rdSel = RS_CODE_FIQ;
        ADDR_W'('h048): begin
          st.rdSel    = RS_CTRL;
          st.ctrlWr   = busWr;
          st.irqRearm = busWr && wBits[0];
          st.fiqRearm = busWr && wBits[1];
        end
        ADDR_W'('h050): begin st.rdSel = RS_IDLE; st.idleWr = busWr; end
        default: ;
      endcase
    end
    if (!busRd) st.rdSel = RS_NONE;
  end

  always_comb begin
    assert_one_target_R11: assert ($onehot0({st.maskWr, st.maskClr, st.maskSet,
      st.swiSet, st.swiClr, st.cfgWr, st.ctrlWr, st.sysWr, st.idleWr}));
  end
endmodule

// File: rtl/bic_datapath.sv
module bic_datapath
  import bic_pkg::*;
#(
  parameter logic [7:0] REVISION = 8'h21
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              st,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NUM_LINES-1:0] lineIn,
  output logic [DATA_W-1:0]    rdata,
  output logic                 irqOut,
  output logic                 fiqOut
);
  logic [NUM_LINES-1:0] inReg, swi, mask, route, pend;
  logic [PRIO_W-1:0]    prio [NUM_LINES];
  logic                 autoIdle, gmask;
  logic [1:0]           idleBits;
  logic [1:0]           armV, firedV, winValid;
  logic [NUM_LINES-1:0] candVec [2];
  logic [LINE_W-1:0]    winIdx [2];
  logic [LINE_W-1:0]    codeV [2];
  logic [LINE_W-1:0]    bankBase;

  assign pend     = inReg | swi;
  assign bankBase = LINE_W'(st.bank) * LINE_W'(BANK_LINES);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inReg <= '0; swi <= '0; mask <= '1; route <= '0;
      autoIdle <= 1'b0; gmask <= 1'b0; idleBits <= '0;
      for (int l = 0; l < NUM_LINES; l++) prio[l] <= '0;
    end else if (st.softReset) begin
      inReg <= '0; swi <= '0; mask <= '1; route <= '0;
      autoIdle <= 1'b0; gmask <= 1'b0; idleBits <= '0;
      for (int l = 0; l < NUM_LINES; l++) prio[l] <= '0;
    end else begin
      inReg <= lineIn;
      if (st.maskWr)  mask[bankBase +: BANK_LINES] <= wdata;
      if (st.maskClr) mask[bankBase +: BANK_LINES] <= mask[bankBase +: BANK_LINES] & ~wdata;
      if (st.maskSet) mask[bankBase +: BANK_LINES] <= mask[bankBase +: BANK_LINES] | wdata;
      if (st.swiSet)  swi[bankBase +: BANK_LINES]  <= swi[bankBase +: BANK_LINES] | wdata;
      if (st.swiClr)  swi[bankBase +: BANK_LINES]  <= swi[bankBase +: BANK_LINES] & ~wdata;
      if (st.cfgWr) begin
        prio[st.line]  <= wdata[PRIO_W+1:2];
        route[st.line] <= wdata[0];
      end
      if (st.sysWr)  autoIdle <= wdata[0];
      if (st.idleWr) idleBits <= wdata[1:0];
      if (st.ctrlWr) gmask    <= wdata[2];
    end
  end

  // one arbiter and one arm/fire stage per request class (0 = IRQ, 1 = FIQ)
  for (genvar k = 0; k < 2; k++) begin : g_class
    logic              rearm, armR, firedR;
    logic [LINE_W-1:0] codeR;

    assign rearm      = (k == 0) ? st.irqRearm : st.fiqRearm;
    assign candVec[k] = pend & ~mask & ((k == 0) ? ~route : route);

    bic_arbiter #(.N(NUM_LINES), .PW(PRIO_W), .IW(LINE_W)) i_arb (
      .cand(candVec[k]), .prio(prio), .valid(winValid[k]), .winner(winIdx[k])
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        armR <= 1'b1; firedR <= 1'b0; codeR <= '0;
      end else if (st.softReset) begin
        armR <= 1'b1; firedR <= 1'b0; codeR <= '0;
      end else if (rearm) begin
        armR <= 1'b1; firedR <= 1'b0;
      end else if (armR && winValid[k] && !gmask) begin
        armR <= 1'b0; firedR <= 1'b1; codeR <= winIdx[k];
      end
    end

    assign armV[k]   = armR;
    assign firedV[k] = firedR;
    assign codeV[k]  = codeR;
  end

  assign irqOut = firedV[0] & ~gmask;
  assign fiqOut = firedV[1] & ~gmask;

  always_comb begin
    rdata = '0;
    unique case (st.rdSel)
      RS_REV:      rdata = DATA_W'(REVISION);
      RS_SYS:      rdata = DATA_W'(autoIdle);
      RS_STAT:     rdata = DATA_W'(1);
      RS_CODE_IRQ: rdata = DATA_W'(codeV[0]);
      RS_CODE_FIQ: rdata = DATA_W'(codeV[1]);
      RS_CTRL:     rdata = DATA_W'({gmask, 2'b00});
      RS_IDLE:     rdata = DATA_W'(idleBits);
      RS_RAW:      rdata = inReg[bankBase +: BANK_LINES];
      RS_MASK:     rdata = mask[bankBase +: BANK_LINES];
      RS_SWI:      rdata = swi[bankBase +: BANK_LINES];
      RS_PEND_IRQ: rdata = candVec[0][bankBase +: BANK_LINES];
      RS_PEND_FIQ: rdata = candVec[1][bankBase +: BANK_LINES];
      RS_CFG:      rdata = DATA_W'({prio[st.line], 1'b0, route[st.line]});
      default:     rdata = '0;
    endcase
  end

  assert_rearm_drops_R9: assert property (@(posedge clk) disable iff (!rstN)
    st.irqRearm |=> !irqOut);
  assert_fire_needs_arm_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(firedV[1]) |-> $past(armV[1]));
  assert_code_frozen_R8: assert property (@(posedge clk) disable iff (!rstN)
    firedV[0] && !st.irqRearm && !st.softReset |=> $stable(codeV[0]));
  assert_gmask_blocks_R10: assert property (@(posedge clk) disable iff (!rstN)
    gmask |=> !$rose(firedV[0]) && !$rose(firedV[1]));
  assert_soft_reset_R2: assert property (@(posedge clk) disable iff (!rstN)
    st.softReset |=> (&mask) && (firedV == 2'b00) && !gmask);
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import bic_pkg::*;
#(
  parameter logic [7:0] REVISION = 8'h21
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWr,
  input  logic                 busRd,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWData,
  output logic [DATA_W-1:0]    busRData,
  input  logic [NUM_LINES-1:0] lineIn,
  output logic                 irqOut,
  output logic                 fiqOut
);
  strobe_t st;

  bic_ctrl i_ctrl (
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .wBits(busWData[2:0]), .st(st)
  );

  bic_datapath #(.REVISION(REVISION)) i_dp (
    .clk(clk), .rstN(rstN), .st(st), .wdata(busWData), .lineIn(lineIn),
    .rdata(busRData), .irqOut(irqOut), .fiqOut(fiqOut)
  );
endmodule

// File: tb/test_banked_irq_ctrl.sv
`timescale 1ns/1ps
module test_banked_irq_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWData = '0;
  logic [31:0] busRData;
  logic [95:0] lineIn = '0;
  logic        irqOut, fiqOut;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  banked_irq_ctrl i_banked_irq_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWData(busWData), .busRData(busRData), .lineIn(lineIn),
    .irqOut(irqOut), .fiqOut(fiqOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWData = d; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); busAddr = a; busRd = 1'b1;
    #1 chk(tag, busRData, exp);
    busRd = 1'b0;
  endtask

  // behavioural reference model of the request outputs
  bit [95:0] mIn, mSwi, mMask, mRoute;
  int        mPrio [96];
  bit        mGm;
  bit        mArm [2], mFired [2];
  bit        wOk [2];
  int        wPr [2], wIdx [2];

  function automatic void mReset();
    mIn = '0; mSwi = '0; mMask = '1; mRoute = '0; mGm = 1'b0;
    for (int l = 0; l < 96; l++) mPrio[l] = 0;
    for (int k = 0; k < 2; k++) begin mArm[k] = 1'b1; mFired[k] = 1'b0; end
  endfunction

  always @(posedge clk) begin
    if (!rstN) mReset();
    else begin
      for (int k = 0; k < 2; k++) begin
        wOk[k] = 1'b0;
        for (int l = 0; l < 96; l++)
          if ((mIn[l] | mSwi[l]) && !mMask[l] && (int'(mRoute[l]) == k) &&
              (!wOk[k] || mPrio[l] <= wPr[k])) begin
            wOk[k] = 1'b1; wPr[k] = mPrio[l]; wIdx[k] = l;
          end
      end
      for (int k = 0; k < 2; k++) begin
        if (busWr && busAddr == 12'h048 && busWData[k]) begin
          mFired[k] = 1'b0; mArm[k] = 1'b1;
        end else if (mArm[k] && wOk[k] && !mGm) begin
          mFired[k] = 1'b1; mArm[k] = 1'b0;
        end
      end
      if (busWr) begin
        if (busAddr[11:7] == 5'h01 && busAddr[6:5] < 2'd3 && busAddr[1:0] == 2'b00) begin
          int b;
          b = int'(busAddr[6:5]) * 32;
          case (busAddr[4:2])
            3'd1: mMask[b +: 32] = busWData;
            3'd2: mMask[b +: 32] = mMask[b +: 32] & ~busWData;
            3'd3: mMask[b +: 32] = mMask[b +: 32] | busWData;
            3'd4: mSwi[b +: 32]  = mSwi[b +: 32] | busWData;
            3'd5: mSwi[b +: 32]  = mSwi[b +: 32] & ~busWData;
            default: ;
          endcase
        end else if (busAddr >= 12'h100 && busAddr < 12'h280 && busAddr[1:0] == 2'b00) begin
          mPrio[(busAddr - 12'h100) >> 2]  = int'(busWData[7:2]);
          mRoute[(busAddr - 12'h100) >> 2] = busWData[0];
        end else if (busAddr == 12'h048) mGm = busWData[2];
      end
      mIn = lineIn;
      if (busWr && busAddr == 12'h010 && busWData[1]) mReset();
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      chk("R8 irqOut vs model", {31'b0, irqOut}, {31'b0, mFired[0] && !mGm});
      chk("R8 fiqOut vs model", {31'b0, fiqOut}, {31'b0, mFired[1] && !mGm});
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 irqOut in reset", {31'b0, irqOut}, 32'h0);
    rstN = 1'b1;
    // R1 identity and status
    rd(12'h000, 32'h21, "R1 revision");
    rd(12'h014, 32'h1, "R1 reset done");
    rd(12'h084, 32'hFFFF_FFFF, "R2 mask reset");
    rd(12'h040, 32'h0, "R2 irq code reset");
    rd(12'h048, 32'h0, "R2 control reset");
    // R3 raw input and mask clear, R5 pending views
    @(negedge clk); lineIn[5] = 1'b1;
    rd(12'h080, 32'h20, "R3 raw input");
    rd(12'h098, 32'h0, "R5 masked pending");
    wr(12'h088, 32'h20);
    @(negedge clk);
    chk("R8 irq fires", {31'b0, irqOut}, 32'h1);
    rd(12'h084, 32'hFFFF_FFDF, "R3 mask after clear");
    rd(12'h098, 32'h20, "R5 pending irq view");
    rd(12'h040, 32'd5, "R7 first code");
    // R7 tie goes to higher line; R9 rearm
    @(negedge clk); lineIn[40] = 1'b1;
    wr(12'h0A8, 32'h100);
    rd(12'h040, 32'd5, "R8 code frozen");
    wr(12'h048, 32'h1);
    chk("R9 rearm drops", {31'b0, irqOut}, 32'h0);
    @(negedge clk);
    chk("R9 refire", {31'b0, irqOut}, 32'h1);
    rd(12'h040, 32'd40, "R7 tie to higher line");
    // R6 config words, R7 lowest value wins
    wr(12'h114, 32'h0C);
    wr(12'h1A0, 32'h1C);
    wr(12'h27C, 32'hFFFF_FFFF);
    rd(12'h114, 32'h0C, "R6 config line 5");
    rd(12'h27C, 32'hFD, "R6 config line 95");
    wr(12'h048, 32'h1);
    rd(12'h040, 32'd5, "R7 lower value wins");
    // FIQ routing
    wr(12'h114, 32'h0D);
    rd(12'h09C, 32'h20, "R5 pending fiq view");
    rd(12'h098, 32'h0, "R5 irq view excludes fiq");
    rd(12'h044, 32'd5, "R7 fiq code");
    chk("R8 fiq fires", {31'b0, fiqOut}, 32'h1);
    // R10 global mask
    wr(12'h048, 32'h4);
    chk("R10 irq blocked", {31'b0, irqOut}, 32'h0);
    chk("R10 fiq blocked", {31'b0, fiqOut}, 32'h0);
    rd(12'h048, 32'h4, "R1 global mask readback");
    wr(12'h048, 32'h5);
    repeat (3) @(negedge clk);
    chk("R10 no fire while masked", {31'b0, irqOut}, 32'h0);
    wr(12'h048, 32'h0);
    @(negedge clk);
    chk("R10 fires after unmask", {31'b0, irqOut}, 32'h1);
    rd(12'h040, 32'd40, "R7 code after unmask");
    // R4 software interrupts on bank 2, line 67
    wr(12'h0D0, 32'h8);
    rd(12'h0D0, 32'h8, "R4 swi readback");
    rd(12'h0D8, 32'h0, "R5 swi masked");
    wr(12'h0C8, 32'h8);
    rd(12'h0D8, 32'h8, "R4 swi pending");
    rd(12'h0C4, 32'hFFFF_FFF7, "R3 bank2 mask");
    wr(12'h048, 32'h1);
    rd(12'h040, 32'd67, "R7 swi wins");
    rd(12'h0C0, 32'h0, "R4 raw excludes swi");
    wr(12'h0D4, 32'h8);
    rd(12'h0D8, 32'h0, "R4 swi cleared");
    rd(12'h0D0, 32'h0, "R4 swi bits cleared");
    rd(12'h0D4, 32'h0, "R4 clear alias reads 0");
    chk("R8 stays high", {31'b0, irqOut}, 32'h1);
    // R3 mask set
    wr(12'h0CC, 32'h8);
    rd(12'h0C4, 32'hFFFF_FFFF, "R3 mask set");
    rd(12'h088, 32'h0, "R3 clear alias reads 0");
    rd(12'h08C, 32'h0, "R3 set alias reads 0");
    // R11 ignored accesses
    wr(12'h0E4, 32'h0);
    wr(12'h0E8, 32'hFFFF_FFFF);
    rd(12'h0E4, 32'h0, "R11 bank 3 reads 0");
    rd(12'h0A4, 32'hFFFF_FEFF, "R11 bank1 untouched");
    rd(12'h0C4, 32'hFFFF_FFFF, "R11 bank2 untouched");
    rd(12'h084, 32'hFFFF_FFDF, "R11 bank0 untouched");
    wr(12'h280, 32'hFC);
    rd(12'h280, 32'h0, "R11 config beyond 95");
    wr(12'h116, 32'h0);
    rd(12'h114, 32'h0D, "R11 unaligned write ignored");
    wr(12'h040, 32'h55);
    rd(12'h040, 32'd67, "R11 code read-only");
    // R1 system and idle bits
    wr(12'h010, 32'h1);
    rd(12'h010, 32'h1, "R1 autoidle");
    wr(12'h050, 32'hFF);
    rd(12'h050, 32'h3, "R1 idle bits");
    // R2 soft reset
    wr(12'h010, 32'h2);
    chk("R2 irq low after soft reset", {31'b0, irqOut}, 32'h0);
    chk("R2 fiq low after soft reset", {31'b0, fiqOut}, 32'h0);
    rd(12'h010, 32'h0, "R2 sys cleared");
    rd(12'h050, 32'h0, "R2 idle cleared");
    rd(12'h084, 32'hFFFF_FFFF, "R2 mask restored");
    rd(12'h114, 32'h0, "R2 config cleared");
    rd(12'h040, 32'h0, "R2 irq code cleared");
    rd(12'h044, 32'h0, "R2 fiq code cleared");
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule